// File: doc/BRIEF.md
# Quadrature Position Decoder with Index-Driven Zeroing

This block turns the two phase signals of an incremental encoder into a signed-direction position count. Every edge on either phase moves the count by one, so each line of the encoder gives four counts. The count runs from zero up to a programmable ceiling. Moving forward past the ceiling gives zero, and moving backward below zero gives the ceiling.

A third input, the index, marks one point per revolution. A mode select decides what a rising index edge does to the count. It can zero the count every time. It can zero the count only once, until software re-arms it. It can leave the count alone. Any index rising edge also sets a sticky marker flag, and software clears that flag with a one-cycle pulse. The clear pulse re-arms the once-only mode.

All three encoder inputs are asynchronous. Each passes through a two-flop synchronizer before edge detection. The index path and the phase path are decoded on the same synchronized timebase, so an index edge that falls close to a phase edge is never lost. If a phase edge and an index edge land in the same cycle, the zeroing takes priority. If both phases change in one cycle, the step is treated as illegal: the count holds and a sticky phase-error flag rises.

Top module: `quad_index_decoder`

## Requirements
- R1: `enc_a`, `enc_b` and `enc_idx` each pass through two synchronizer flops. A phase change that is first sampled at a rising clock edge appears on `pos_count` after the third rising edge, counting from that first sample.
- R2: Taking the phase state as {A,B}, the forward sequence is 00→10→11→01→00, and each step of it adds one. The reverse sequence is 00→01→11→10→00, and each step of it subtracts one. `dir_fwd` goes to 1 after a forward step and to 0 after a reverse step, and holds between steps.
- R3: A forward step taken at or above `pos_max` gives 0. A reverse step taken at 0 gives `pos_max`.
- R4: A change of both phases in one cycle leaves `pos_count` unchanged. It sets `phase_err`, which stays set until reset.
- R5: With `idx_mode` = 2'b00, every rising index edge sets `pos_count` to 0.
- R6: With `idx_mode` = 2'b10, a rising index edge sets `pos_count` to 0 only while `idx_marker` is 0. While `idx_marker` is 1, index edges leave the count unchanged.
- R7: With `idx_mode` = 2'b01 or 2'b11, index edges never change `pos_count`.
- R8: Every rising index edge sets `idx_marker` in any mode. The flag stays set until a `marker_clr` pulse. If an index edge and a clear arrive in the same cycle, the flag is set.
- R9: After a `marker_clr` pulse, the next rising index edge in mode 2'b10 zeroes the count again.
- R10: If an index zeroing and a phase step take effect in the same cycle, the result is 0. An index edge one cycle before a phase edge gives 0 and then ±1. An index edge two cycles after a phase edge gives 0. In all three cases the marker is set.
- R11: While `rst` is high, `pos_count` = 0, `dir_fwd` = 1, `idx_marker` = 0 and `phase_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index, asynchronous |
| idx_mode | input | 2 | Index action: 00 zero every time, 10 zero once per arm, 01/11 no zeroing |
| pos_max | input | POS_W | Count ceiling |
| marker_clr | input | 1 | One-cycle pulse that clears the marker and re-arms once-only zeroing |
| pos_count | output | POS_W | Position count |
| dir_fwd | output | 1 | Direction of the last step, 1 = forward |
| idx_marker | output | 1 | Sticky flag set by an index edge |
| phase_err | output | 1 | Sticky flag set by an illegal phase transition |

## Verification
The assertions run on every cycle and check the following:
- After any zero request, the count is 0 on the next cycle.
- A legal step, including either wrap, changes the count by exactly one.
- An illegal step only ever follows a change of both phases, and it leaves the count untouched.
- The marker sets after an index edge and never drops without a clear.
- Once-only zeroing leaves an armed-out count alone.

Only the bench scenarios can show the following:
- The three-edge synchronizer latency.
- The full direction sequences.
- The way the modes differ from one another.
- The set-over-clear priority.
- Capture of an index edge placed one cycle before or two cycles after a phase edge.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [1:0] {
        IDXM_EVERY = 2'b00,
        IDXM_OFF_A = 2'b01,
        IDXM_ONCE  = 2'b10,
        IDXM_OFF_B = 2'b11
    } idx_mode_e;

    typedef struct packed {
        logic fwd;
        logic rev;
        logic bad;
    } step_t;

    localparam int unsigned PIN_CNT = 3;
    localparam int unsigned PIN_A   = 2;
    localparam int unsigned PIN_B   = 1;
    localparam int unsigned PIN_I   = 0;

    // successor of {A,B} in forward order
    function automatic logic [1:0] ph_fwd(input logic [1:0] ab);
        return {~ab[0], ab[1]};
    endfunction

    // successor of {A,B} in reverse order
    function automatic logic [1:0] ph_rev(input logic [1:0] ab);
        return {ab[0], ~ab[1]};
    endfunction

    function automatic step_t classify(input logic [1:0] prv, input logic [1:0] cur);
        step_t s;
        s = '0;
        if (cur != prv) begin
            if (cur == ph_fwd(prv))      s.fwd = 1'b1;
            else if (cur == ph_rev(prv)) s.rev = 1'b1;
            else                         s.bad = 1'b1;
        end
        return s;
    endfunction

    function automatic logic zero_allowed(input idx_mode_e m, input logic marker);
        case (m)
            IDXM_EVERY: return 1'b1;
            IDXM_ONCE:  return ~marker;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= '0;
            else     stg[g] <= stg[g-1];
        end
    end

    assign dout = stg[LAST];
endmodule

// File: rtl/qdec_edge.sv
module qdec_edge
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ab_s,
    input  logic       idx_s,
    output step_t      step,
    output logic       idx_rise
);
    logic [1:0] ab_prev;
    logic       idx_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ab_prev  <= 2'b00;
            idx_prev <= 1'b0;
        end else begin
            ab_prev  <= ab_s;
            idx_prev <= idx_s;
        end
    end

    assign step     = classify(ab_prev, ab_s);
    assign idx_rise = idx_s & ~idx_prev;

    // R4
    illegal_both_chk: assert property (@(posedge clk) disable iff (rst)
        step.bad |-> ((ab_s ^ ab_prev) == 2'b11));

    // R2
    one_step_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (ab_s != ab_prev) |-> $onehot({step.fwd, step.rev, step.bad}));
endmodule

// File: rtl/qdec_poscnt.sv
module qdec_poscnt
    import qdec_pkg::*;
#(
    parameter int unsigned POS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  step_t            step,
    input  logic             zero_req,
    input  logic [POS_W-1:0] max_val,
    output logic [POS_W-1:0] cnt,
    output logic             dir_fwd
);
    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    logic [POS_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt;
        if (zero_req)
            cnt_nxt = '0;
        else if (step.fwd)
            cnt_nxt = (cnt >= max_val) ? '0 : cnt + ONE;
        else if (step.rev)
            cnt_nxt = (cnt == '0) ? max_val : cnt - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            dir_fwd <= 1'b1;
        end else begin
            cnt <= cnt_nxt;
            if (step.fwd)      dir_fwd <= 1'b1;
            else if (step.rev) dir_fwd <= 1'b0;
        end
    end

    // R10
    zero_wins_chk: assert property (@(posedge clk) disable iff (rst)
        zero_req |=> (cnt == '0));

    // R2
    fwd_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (step.fwd && !zero_req && cnt < max_val) |=> (cnt == $past(cnt) + ONE));

    // R3
    fwd_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step.fwd && !zero_req && cnt >= max_val) |=> (cnt == '0));

    // R3
    rev_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step.rev && !zero_req && cnt == '0) |=> (cnt == $past(max_val)));

    // R4
    bad_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step.bad && !zero_req) |=> $stable(cnt));
endmodule

// File: rtl/quad_index_decoder.sv
module quad_index_decoder
    import qdec_pkg::*;
#(
    parameter int unsigned POS_W     = 16,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    input  logic [1:0]       idx_mode,
    input  logic [POS_W-1:0] pos_max,
    input  logic             marker_clr,
    output logic [POS_W-1:0] pos_count,
    output logic             dir_fwd,
    output logic             idx_marker,
    output logic             phase_err
);
    logic [PIN_CNT-1:0] pins_raw;
    logic [PIN_CNT-1:0] pins_s;
    step_t              step;
    logic               idx_rise;
    logic               zero_req;
    idx_mode_e          mode_e;
    logic               marker_q;
    logic               perr_q;

    assign pins_raw[PIN_A] = enc_a;
    assign pins_raw[PIN_B] = enc_b;
    assign pins_raw[PIN_I] = enc_idx;

    qdec_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pins_raw),
        .dout (pins_s)
    );

    qdec_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .ab_s     ({pins_s[PIN_A], pins_s[PIN_B]}),
        .idx_s    (pins_s[PIN_I]),
        .step     (step),
        .idx_rise (idx_rise)
    );

    assign mode_e   = idx_mode_e'(idx_mode);
    assign zero_req = idx_rise & zero_allowed(mode_e, marker_q);

    qdec_poscnt #(.POS_W(POS_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .zero_req (zero_req),
        .max_val  (pos_max),
        .cnt      (pos_count),
        .dir_fwd  (dir_fwd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            marker_q <= 1'b0;
            perr_q   <= 1'b0;
        end else begin
            if (idx_rise)        marker_q <= 1'b1;
            else if (marker_clr) marker_q <= 1'b0;
            if (step.bad)        perr_q   <= 1'b1;
        end
    end

    assign idx_marker = marker_q;
    assign phase_err  = perr_q;

    // R8
    marker_set_chk: assert property (@(posedge clk) disable iff (rst)
        idx_rise |=> idx_marker);

    // R8
    marker_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (idx_marker && !marker_clr) |=> idx_marker);

    // R6
    once_armed_out_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_e == IDXM_ONCE && idx_marker && idx_rise && step == '0) |=> $stable(pos_count));

    // R7
    off_no_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (idx_mode[0] && idx_rise && step == '0) |=> $stable(pos_count));

    // R4
    perr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        phase_err |=> phase_err);
endmodule

// File: tb/tb_quad_index_decoder.sv
module tb_quad_index_decoder;
    localparam int POS_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic [1:0]       idx_mode = 2'b01;
    logic [POS_W-1:0] pos_max = 16'd7;
    logic             marker_clr = 1'b0;
    logic [POS_W-1:0] pos_count;
    logic             dir_fwd, idx_marker, phase_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    quad_index_decoder #(.POS_W(POS_W)) dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .idx_mode(idx_mode), .pos_max(pos_max), .marker_clr(marker_clr),
        .pos_count(pos_count), .dir_fwd(dir_fwd), .idx_marker(idx_marker),
        .phase_err(phase_err)
    );

    // {A,B} next state, expected dir, expected count
    localparam logic [18:0] VEC [10] = '{
        {2'b11, 1'b1, 16'd2},
        {2'b01, 1'b1, 16'd3},
        {2'b00, 1'b1, 16'd4},
        {2'b01, 1'b0, 16'd3},
        {2'b11, 1'b0, 16'd2},
        {2'b10, 1'b0, 16'd1},
        {2'b00, 1'b0, 16'd0},
        {2'b01, 1'b0, 16'd7},
        {2'b00, 1'b1, 16'd0},
        {2'b10, 1'b1, 16'd1}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fwd_steps(input int n);
        for (int k = 0; k < n; k++) begin
            {enc_a, enc_b} = {~enc_b, enc_a};
            settle();
        end
    endtask

    task automatic idx_pulse();
        enc_idx = 1'b1;
        settle();
        enc_idx = 1'b0;
        settle();
    endtask

    task automatic clr_pulse();
        marker_clr = 1'b1;
        @(negedge clk);
        marker_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        check("R11 count", pos_count, 0);
        check("R11 dir", dir_fwd, 1);
        check("R11 marker", idx_marker, 0);
        check("R11 perr", phase_err, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 latency: new value only after third edge
        {enc_a, enc_b} = 2'b10;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 before third edge", pos_count, 0);
        @(posedge clk);
        @(negedge clk);
        check("R1 after third edge", pos_count, 1);
        settle();

        // R2 R3 table walk, mode 01 (no index action)
        foreach (VEC[v]) begin
            {enc_a, enc_b} = VEC[v][18:17];
            settle();
            check($sformatf("R2/R3 vec %0d count", v), pos_count, VEC[v][15:0]);
            check($sformatf("R2 vec %0d dir", v), dir_fwd, VEC[v][16]);
        end

        // R4 both phases change: 10 -> 01
        {enc_a, enc_b} = 2'b01;
        settle();
        check("R4 count held", pos_count, 1);
        check("R4 perr set", phase_err, 1);
        fwd_steps(1);
        check("R4 perr sticky", phase_err, 1);

        // R7 modes 01 and 11 ignore index for count
        idx_pulse();
        check("R7 mode01 count", pos_count, 2);
        check("R8 marker mode01", idx_marker, 1);
        clr_pulse();
        check("R8 cleared", idx_marker, 0);
        idx_mode = 2'b11;
        idx_pulse();
        check("R7 mode11 count", pos_count, 2);

        // R11 reset mid-run
        rst = 1'b1;
        {enc_a, enc_b} = 2'b00;
        repeat (4) @(negedge clk);
        check("R11 rerst count", pos_count, 0);
        check("R11 rerst marker", idx_marker, 0);
        check("R11 rerst perr", phase_err, 0);
        check("R11 rerst dir", dir_fwd, 1);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R5 mode 00 zeroes each time
        idx_mode = 2'b00;
        fwd_steps(3);
        check("R5 pre", pos_count, 3);
        idx_pulse();
        check("R5 first zero", pos_count, 0);
        check("R8 marker mode00", idx_marker, 1);
        fwd_steps(2);
        idx_pulse();
        check("R5 second zero", pos_count, 0);

        // R6 mode 10 with marker already set: no zeroing
        idx_mode = 2'b10;
        fwd_steps(2);
        idx_pulse();
        check("R6 armed out", pos_count, 2);
        // R9 clear re-arms
        clr_pulse();
        check("R9 marker cleared", idx_marker, 0);
        idx_pulse();
        check("R9 rearmed zero", pos_count, 0);
        check("R9 marker set", idx_marker, 1);
        fwd_steps(1);
        idx_pulse();
        check("R6 second ignored", pos_count, 1);

        // R8 clear in same cycle as index edge: set wins
        enc_idx = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        marker_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        marker_clr = 1'b0;
        check("R8 set over clear", idx_marker, 1);
        enc_idx = 1'b0;
        settle();

        // R10 coincidence cases, mode 00
        idx_mode = 2'b00;
        clr_pulse();
        enc_idx = 1'b1;
        {enc_a, enc_b} = {~enc_b, enc_a};
        settle();
        check("R10 same cycle", pos_count, 0);
        check("R10 same marker", idx_marker, 1);
        enc_idx = 1'b0;
        settle();
        clr_pulse();
        fwd_steps(2);
        enc_idx = 1'b1;
        @(negedge clk);
        {enc_a, enc_b} = {~enc_b, enc_a};
        settle();
        check("R10 index one early", pos_count, 1);
        check("R10 early marker", idx_marker, 1);
        enc_idx = 1'b0;
        settle();
        clr_pulse();
        {enc_a, enc_b} = {~enc_b, enc_a};
        repeat (2) @(negedge clk);
        enc_idx = 1'b1;
        settle();
        check("R10 index two late", pos_count, 0);
        check("R10 late marker", idx_marker, 1);
        enc_idx = 1'b0;
        settle();

        finish_run();
    end
endmodule